// File: doc/BRIEF.md
# Unaligned Load Funnel with Byte Disable and Extension

This block is the memory-facing data path of a load unit. A request carries a byte address, an element width of 1, 2, 4 or 8 bytes, a signed or unsigned flag, a target width for the final value and a per-byte disable mask. The unit clears the low address bits to reach the element's natural boundary. It reads the aligned 64-bit word that holds the element. When the access crosses that natural boundary, it also reads the word that holds the tail. It then joins the two pieces with a little-endian shift-and-OR funnel.

A single mask step then produces the result. It zeroes the disabled bytes, fills the bytes above the element width with the element's sign bit or with zeros, and clears every byte at or above the target width. Memory is reached through two plain synchronous read ports with one cycle of latency. The result is held until the next request finishes, and a one-cycle `done` pulse marks when it is ready.

Top module: `ldf_load_unit`

## Requirements
- R1: After reset, `done`, `rd0_req` and `rd1_req` are 0 and `result` is zero.
- R2: One cycle after `start` is sampled, `rd0_req` is high for exactly one cycle. `rd0_addr` is then the byte address of the 64-bit word that holds the aligned address. The aligned address is `vaddr` with its low `size_log2` bits cleared. `size_log2` values 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R3: `rd1_req` rises in the same cycle as `rd0_req` only when `misal_en` is 1 and the misalignment offset is nonzero. The offset is `vaddr` minus the aligned address. `rd1_addr` is the word address of aligned address + width.
- R4: `done` is a one-cycle pulse. It comes 2 cycles after `start` when there is no tail read, and 3 cycles after `start` when there is one.
- R5: With `misal_en`=1, unsigned, no bytes disabled and `ext_log2`=3, result byte k equals memory byte `vaddr`+k for k < width, and is zero above that. This holds for every offset 0..7.
- R6: With `misal_en`=0 the shift is forced to zero and the result is the element at the aligned address. For 2-byte elements, addresses base+0 and base+1 give the same halfword, and so do base+4 and base+5.
- R7: Bit k of `byte_dis` clears result byte k after the merge. The sign bit is taken after this clearing.
- R8: When `sext_en`=1, every byte from the element width up to 8 takes the element's most significant bit. When `sext_en`=0, those bytes are zero. For example, a 0xFFFF halfword becomes 0xFFFFFFFF when signed and 0x0000FFFF when unsigned, with `ext_log2`=2.
- R9: Result bytes at or above 2^`ext_log2` bytes are zero.
- R10: `result` keeps its value between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a load; sampled only while idle |
| vaddr | input | ADDR_W | Byte address of the element |
| size_log2 | input | 2 | log2 of the element width in bytes |
| sext_en | input | 1 | 1 = signed fill, 0 = zero fill |
| ext_log2 | input | 2 | log2 of the target width in bytes |
| byte_dis | input | WORD_BYTES | Per-result-byte disable |
| misal_en | input | 1 | Enables the misaligned shift and the tail read |
| rd0_req | output | 1 | Head word read request |
| rd0_addr | output | ADDR_W | Head word byte address (low 3 bits zero) |
| rd0_data | input | 8*WORD_BYTES | Head word, valid the cycle after the request |
| rd1_req | output | 1 | Tail word read request |
| rd1_addr | output | ADDR_W | Tail word byte address (low 3 bits zero) |
| rd1_data | input | 8*WORD_BYTES | Tail word, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8*WORD_BYTES | Merged, masked and extended value |

## Verification
The assertions assume that memory answers every request on the next cycle and keeps its read data stable through the capture cycle. They also assume that `start` is raised only while the unit is idle, so that each read request follows a `start` one cycle earlier. The bench keeps to this by modelling memory as a byte array that registers a word on each request. It raises `start` for a single cycle and waits for `done` before it issues the next request, across every width, offset, fill mode and extension setting.

// File: rtl/ldf_pkg.sv
package ldf_pkg;

   typedef enum logic [1:0] {
      LDF_IDLE,
      LDF_REQ,
      LDF_CAP,
      LDF_MERGE
   } ldf_state_e;

endpackage

// File: rtl/ldf_addr_split.sv
module ldf_addr_split #(
   parameter  int ADDR_W     = 32,
   parameter  int WORD_BYTES = 8,
   localparam int OFF_W      = $clog2(WORD_BYTES),
   localparam int SZ_W       = $clog2(OFF_W + 1)
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [SZ_W-1:0]   size_log2,
   input  logic              misal_en,
   output logic [ADDR_W-1:0] head_word,
   output logic [ADDR_W-1:0] tail_word,
   output logic [OFF_W-1:0]  head_lane,
   output logic [OFF_W-1:0]  tail_lane,
   output logic [OFF_W-1:0]  shift_off,
   output logic              need_tail
);

   logic [ADDR_W-1:0] low_mask;
   logic [ADDR_W-1:0] aligned;
   logic [ADDR_W-1:0] misal;
   logic [ADDR_W-1:0] tail_addr;

   assign low_mask  = (ADDR_W'(1) << size_log2) - ADDR_W'(1);
   assign aligned   = vaddr & ~low_mask;
   assign misal     = vaddr & low_mask;
   assign tail_addr = aligned + low_mask + ADDR_W'(1);

   assign need_tail = misal_en && (misal != '0);
   assign shift_off = misal_en ? misal[OFF_W-1:0] : '0;

   assign head_lane = aligned[OFF_W-1:0];
   assign tail_lane = tail_addr[OFF_W-1:0];
   assign head_word = {aligned[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign tail_word = {tail_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/ldf_funnel.sv
module ldf_funnel #(
   parameter  int WORD_BYTES = 8,
   localparam int WORD_W     = 8 * WORD_BYTES,
   localparam int OFF_W      = $clog2(WORD_BYTES),
   localparam int SZ_W       = $clog2(OFF_W + 1),
   localparam int SH_W       = OFF_W + 4
) (
   input  logic [WORD_W-1:0] head_data,
   input  logic [WORD_W-1:0] tail_data,
   input  logic [OFF_W-1:0]  head_lane,
   input  logic [OFF_W-1:0]  tail_lane,
   input  logic [OFF_W-1:0]  shift_off,
   input  logic [SZ_W-1:0]   size_log2,
   input  logic              use_tail,
   output logic [WORD_W-1:0] merged
);

   logic [SH_W-1:0]   head_sh;
   logic [SH_W-1:0]   tail_sh;
   logic [SH_W-1:0]   off_sh;
   logic [SH_W-1:0]   elem_bits;
   logic [SH_W-1:0]   up_sh;
   logic [WORD_W-1:0] elem_mask;
   logic [WORD_W-1:0] head_elem;
   logic [WORD_W-1:0] tail_elem;
   logic [WORD_W-1:0] low_part;
   logic [WORD_W-1:0] high_part;

   generate
      for (genvar b = 0; b < WORD_BYTES; b++) begin : g_elem_mask
         assign elem_mask[8*b +: 8] = (b < (1 << size_log2)) ? 8'hFF : 8'h00;
      end
   endgenerate

   assign head_sh   = SH_W'(head_lane) << 3;
   assign tail_sh   = SH_W'(tail_lane) << 3;
   assign off_sh    = SH_W'(shift_off) << 3;
   assign elem_bits = SH_W'(8) << size_log2;
   assign up_sh     = elem_bits - off_sh;

   assign head_elem = (head_data >> head_sh) & elem_mask;
   assign tail_elem = (tail_data >> tail_sh) & elem_mask;
   assign low_part  = head_elem >> off_sh;
   assign high_part = use_tail ? (tail_elem << up_sh) : '0;
   assign merged    = (low_part | high_part) & elem_mask;

endmodule

// File: rtl/ldf_extend.sv
module ldf_extend #(
   parameter  int WORD_BYTES = 8,
   localparam int WORD_W     = 8 * WORD_BYTES,
   localparam int OFF_W      = $clog2(WORD_BYTES),
   localparam int SZ_W       = $clog2(OFF_W + 1),
   localparam int IDX_W      = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0]     merged,
   input  logic [WORD_BYTES-1:0] byte_dis,
   input  logic [SZ_W-1:0]       size_log2,
   input  logic [SZ_W-1:0]       ext_log2,
   input  logic                  sext_en,
   output logic [WORD_W-1:0]     ext_data
);

   logic [WORD_W-1:0] kept;
   logic [IDX_W-1:0]  msb_idx;
   logic              fill_bit;

   assign msb_idx  = IDX_W'((32'd8 << size_log2) - 32'd1);
   assign fill_bit = sext_en & kept[msb_idx];

   generate
      for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
         logic above_elem;
         logic inside_ext;
         assign kept[8*b +: 8]     = byte_dis[b] ? 8'h00 : merged[8*b +: 8];
         assign above_elem         = (b >= (1 << size_log2));
         assign inside_ext         = (b < (1 << ext_log2));
         assign ext_data[8*b +: 8] = !inside_ext ? 8'h00 :
                                     above_elem  ? {8{fill_bit}} : kept[8*b +: 8];
      end
   endgenerate

endmodule

// File: rtl/ldf_load_unit.sv
module ldf_load_unit
   import ldf_pkg::*;
#(
   parameter  int ADDR_W     = 32,
   parameter  int WORD_BYTES = 8,
   localparam int WORD_W     = 8 * WORD_BYTES,
   localparam int OFF_W      = $clog2(WORD_BYTES),
   localparam int SZ_W       = $clog2(OFF_W + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ADDR_W-1:0]     vaddr,
   input  logic [SZ_W-1:0]       size_log2,
   input  logic                  sext_en,
   input  logic [SZ_W-1:0]       ext_log2,
   input  logic [WORD_BYTES-1:0] byte_dis,
   input  logic                  misal_en,
   output logic                  rd0_req,
   output logic [ADDR_W-1:0]     rd0_addr,
   input  logic [WORD_W-1:0]     rd0_data,
   output logic                  rd1_req,
   output logic [ADDR_W-1:0]     rd1_addr,
   input  logic [WORD_W-1:0]     rd1_data,
   output logic                  done,
   output logic [WORD_W-1:0]     result
);

   generate
      if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("WORD_BYTES must be a power of two of at least 2");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("ADDR_W must exceed the word offset width");
      end
   endgenerate

   ldf_state_e            state;
   logic [ADDR_W-1:0]     va_q;
   logic [SZ_W-1:0]       size_q;
   logic [SZ_W-1:0]       ext_q;
   logic                  sext_q;
   logic                  mis_q;
   logic [WORD_BYTES-1:0] dis_q;
   logic [WORD_W-1:0]     head_q;
   logic [WORD_W-1:0]     tail_q;

   logic [OFF_W-1:0]      head_lane;
   logic [OFF_W-1:0]      tail_lane;
   logic [OFF_W-1:0]      shift_off;
   logic                  need_tail;
   logic [WORD_W-1:0]     head_in;
   logic [WORD_W-1:0]     tail_in;
   logic [WORD_W-1:0]     merged;
   logic [WORD_W-1:0]     ext_data;

   ldf_addr_split #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) i_split (
      .vaddr     (va_q),
      .size_log2 (size_q),
      .misal_en  (mis_q),
      .head_word (rd0_addr),
      .tail_word (rd1_addr),
      .head_lane (head_lane),
      .tail_lane (tail_lane),
      .shift_off (shift_off),
      .need_tail (need_tail)
   );

   assign head_in = (state == LDF_MERGE) ? head_q : rd0_data;
   assign tail_in = (state == LDF_MERGE) ? tail_q : rd1_data;

   ldf_funnel #(.WORD_BYTES(WORD_BYTES)) i_funnel (
      .head_data (head_in),
      .tail_data (tail_in),
      .head_lane (head_lane),
      .tail_lane (tail_lane),
      .shift_off (shift_off),
      .size_log2 (size_q),
      .use_tail  (need_tail),
      .merged    (merged)
   );

   ldf_extend #(.WORD_BYTES(WORD_BYTES)) i_extend (
      .merged    (merged),
      .byte_dis  (dis_q),
      .size_log2 (size_q),
      .ext_log2  (ext_q),
      .sext_en   (sext_q),
      .ext_data  (ext_data)
   );

   assign rd0_req = (state == LDF_REQ);
   assign rd1_req = (state == LDF_REQ) && need_tail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= LDF_IDLE;
         va_q   <= '0;
         size_q <= '0;
         ext_q  <= '0;
         sext_q <= 1'b0;
         mis_q  <= 1'b0;
         dis_q  <= '0;
         head_q <= '0;
         tail_q <= '0;
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            LDF_IDLE: begin
               if (start) begin
                  va_q   <= vaddr;
                  size_q <= size_log2;
                  ext_q  <= ext_log2;
                  sext_q <= sext_en;
                  mis_q  <= misal_en;
                  dis_q  <= byte_dis;
                  state  <= LDF_REQ;
               end
            end
            LDF_REQ: state <= LDF_CAP;
            LDF_CAP: begin
               if (need_tail) begin
                  head_q <= rd0_data;
                  tail_q <= rd1_data;
                  state  <= LDF_MERGE;
               end else begin
                  result <= ext_data;
                  done   <= 1'b1;
                  state  <= LDF_IDLE;
               end
            end
            LDF_MERGE: begin
               result <= ext_data;
               done   <= 1'b1;
               state  <= LDF_IDLE;
            end
            default: state <= LDF_IDLE;
         endcase
      end
   end

   function automatic logic [WORD_W-1:0] low_bytes(input logic [SZ_W-1:0] lg);
      logic [WORD_W-1:0] m;
      for (int b = 0; b < WORD_BYTES; b++) begin
         m[8*b +: 8] = (b < (1 << lg)) ? 8'hFF : 8'h00;
      end
      return m;
   endfunction

   // R2
   head_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd0_req |-> $past(start));

   // R3
   tail_with_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd1_req |-> rd0_req);

   // R4
   aligned_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_req && !rd1_req) |-> ##2 done);

   // R4
   straddle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd1_req |-> ##3 done);

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !sext_q) |-> ((result & ~low_bytes(size_q)) == '0));

   // R9
   ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((result & ~low_bytes(ext_q)) == '0));

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

endmodule

// File: tb/test_ldf_load_unit.sv
module test_ldf_load_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] vaddr = '0;
   logic [1:0]  size_log2 = '0;
   logic        sext_en = 1'b0;
   logic [1:0]  ext_log2 = '0;
   logic [7:0]  byte_dis = '0;
   logic        misal_en = 1'b0;
   logic        rd0_req, rd1_req, done;
   logic [31:0] rd0_addr, rd1_addr;
   logic [63:0] rd0_data = '0;
   logic [63:0] rd1_data = '0;
   logic [63:0] result;

   logic [7:0]  mem [0:255];
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   ldf_load_unit i_ldf_load_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
      .size_log2(size_log2), .sext_en(sext_en), .ext_log2(ext_log2),
      .byte_dis(byte_dis), .misal_en(misal_en),
      .rd0_req(rd0_req), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
      .rd1_req(rd1_req), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
      .done(done), .result(result)
   );

   always @(posedge clk) begin
      if (rd0_req)
         for (int k = 0; k < 8; k++) rd0_data[8*k +: 8] <= mem[((rd0_addr & 32'hF8) + k) & 255];
      if (rd1_req)
         for (int k = 0; k < 8; k++) rd1_data[8*k +: 8] <= mem[((rd1_addr & 32'hF8) + k) & 255];
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] model(int va, int sz, bit sx, int el, logic [7:0] dis, bit men);
      int w = 1 << sz;
      int al = va & ~(w - 1);
      int sh = men ? va - al : 0;
      logic [63:0] v = '0;
      for (int k = 0; k < w; k++) v[8*k +: 8] = dis[k] ? 8'h00 : mem[(al + sh + k) & 255];
      if (sx && v[8*w-1]) for (int k = w; k < 8; k++) v[8*k +: 8] = 8'hFF;
      for (int k = (1 << el); k < 8; k++) v[8*k +: 8] = 8'h00;
      return v;
   endfunction

   task automatic run_load(input int va, input int sz, input bit sx, input int el,
                           input logic [7:0] dis, input bit men, input string tag,
                           output logic [63:0] got);
      int w = 1 << sz;
      int al = va & ~(w - 1);
      bit tail = men && (va != al);
      int cyc = 0;
      bit saw1 = 1'b0;
      logic [31:0] a0 = '1;
      logic [31:0] a1 = '1;
      logic [63:0] exp = model(va, sz, sx, el, dis, men);
      @(negedge clk);
      start = 1'b1; vaddr = 32'(va); size_log2 = 2'(sz); sext_en = sx;
      ext_log2 = 2'(el); byte_dis = dis; misal_en = men;
      @(negedge clk);
      start = 1'b0; vaddr = '0; byte_dis = '0;
      while (!done && cyc < 20) begin
         if (rd0_req) a0 = rd0_addr;
         if (rd1_req) begin saw1 = 1'b1; a1 = rd1_addr; end
         @(negedge clk);
         cyc++;
      end
      got = result;
      // R2 head word address
      chk(a0 == 32'(al & ~7), "R2 head address", 64'(a0), 64'(al & ~7));
      // R3 tail read presence and address
      chk(saw1 == tail, "R3 tail request", 64'(saw1), 64'(tail));
      if (tail) chk(a1 == 32'((al + w) & ~7), "R3 tail address", 64'(a1), 64'((al + w) & ~7));
      // R4 latency
      chk(cyc == (tail ? 3 : 2), "R4 done latency", 64'(cyc), 64'(tail ? 3 : 2));
      chk(result == exp, tag, result, exp);
   endtask

   task automatic t_reset();
      chk(done == 1'b0 && rd0_req == 1'b0 && rd1_req == 1'b0, "R1 reset controls",
          64'({done, rd0_req, rd1_req}), 64'd0);
      chk(result == '0, "R1 reset result", result, 64'd0);
   endtask

   task automatic t_sweep();
      logic [63:0] r;
      for (int sz = 0; sz < 4; sz++)
         for (int off = 0; off < 8; off++)
            for (int sx = 0; sx < 2; sx++)
               run_load(32'h50 + off, sz, sx[0], 3, 8'h00, 1'b1,
                        sx ? "R8 signed sweep" : "R5 unsigned sweep", r);
   endtask

   task automatic t_no_misal();
      logic [63:0] r0, r1, r4, r5, rx;
      for (int sz = 1; sz < 4; sz++)
         for (int off = 0; off < 8; off++)
            run_load(32'h90 + off, sz, 1'b0, 3, 8'h00, 1'b0, "R6 shift forced zero", rx);
      run_load(32'h80, 1, 1'b0, 3, 8'h00, 1'b0, "R6 halfword 0", r0);
      run_load(32'h81, 1, 1'b0, 3, 8'h00, 1'b0, "R6 halfword 0 odd", r1);
      chk(r0 == r1, "R6 offsets 0 and 1 same element", r1, r0);
      run_load(32'h84, 1, 1'b0, 3, 8'h00, 1'b0, "R6 halfword 2", r4);
      run_load(32'h85, 1, 1'b0, 3, 8'h00, 1'b0, "R6 halfword 2 odd", r5);
      chk(r4 == r5, "R6 offsets 4 and 5 same element", r5, r4);
      chk(r4 == {48'd0, mem[8'h85], mem[8'h84]}, "R6 halfword 2 value", r4, {48'd0, mem[8'h85], mem[8'h84]});
   endtask

   task automatic t_disable();
      logic [63:0] r;
      run_load(32'h63, 3, 1'b0, 3, 8'hA5, 1'b1, "R7 disable straddle", r);
      run_load(32'h61, 2, 1'b1, 3, 8'h0F, 1'b1, "R7 all disabled", r);
      chk(r == 64'd0, "R7 all disabled zero", r, 64'd0);
      run_load(32'h70, 1, 1'b1, 3, 8'h02, 1'b1, "R7 sign after disable", r);
      chk(r == 64'h12, "R7 sign after disable value", r, 64'h12);
   endtask

   task automatic t_extend();
      logic [63:0] r;
      run_load(32'h40, 1, 1'b1, 2, 8'h00, 1'b1, "R8 signed FFFF", r);
      chk(r == 64'hFFFF_FFFF, "R8 signed FFFF value", r, 64'hFFFF_FFFF);
      run_load(32'h40, 1, 1'b0, 2, 8'h00, 1'b1, "R8 unsigned FFFF", r);
      chk(r == 64'h0000_FFFF, "R8 unsigned FFFF value", r, 64'h0000_FFFF);
      for (int el = 0; el < 4; el++) run_load(32'h55, 2, 1'b1, el, 8'h00, 1'b1, "R9 target width", r);
      run_load(32'h71, 0, 1'b1, 1, 8'h00, 1'b1, "R9 byte to halfword", r);
   endtask

   task automatic t_hold();
      logic [63:0] r;
      run_load(32'h67, 3, 1'b1, 3, 8'h00, 1'b1, "R10 load", r);
      repeat (6) @(negedge clk);
      chk(result == r, "R10 result held", result, r);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 29 + 11);
      mem[8'h40] = 8'hFF; mem[8'h41] = 8'hFF;
      mem[8'h70] = 8'h12; mem[8'h71] = 8'h9C;
      mem[8'h57] = 8'h85; mem[8'h5B] = 8'hC3;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_sweep();
      t_no_misal();
      t_disable();
      t_extend();
      t_hold();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R4 watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule